// File: doc/BRIEF.md
# Framed Stream Deframer with Integrity Check

This block sits on a 64-bit ready/valid word stream that carries framed packets. A frame is a fixed start word, any number of packet words, a fixed end word, and one trailer word. While idle the block hunts for the start word and throws away everything else. Once it finds one, it strips the framing, forwards only the packet words downstream, and marks the last packet word with a last flag. To do this it keeps one word of lookahead, so it can tell which packet word comes just before the end word.

As the packet words pass through, the block computes three values. The first is a 16-bit CRC over the header, which is one or two words long depending on a flag bit in the first packet word. The second is a 32-bit CRC over the remaining payload words. The third is a word count that includes the end word. After the trailer arrives, the block compares these values with the trailer fields and issues a one-cycle status strobe that carries one error bit for each field. If a frame runs past the word limit without an end word, the block closes the packet, reports an overrun and goes back to hunting. Downstream backpressure stalls the input, so no word is lost.

Top module: `frame_deframer`

## Requirements
- R1: While hunting, every input word other than the start word 0x9E6774129E677412 is accepted and dropped. This includes a stray end word. Nothing is forwarded and no status is produced.
- R2: The packet words between the start word and the end word 0x2A1D632F2A1D632F come out on out_data in their original order. The start word, the end word and the trailer word are never forwarded.
- R3: out_last is high on exactly the forwarded word that came directly before the end word, and is low on every other forwarded word. A frame with no packet words forwards nothing.
- R4: The trailer is the word that follows the end word. Its field layout is: bits [63:48] header CRC, bits [47:32] word count, bits [31:0] payload CRC. The cycle after the trailer is accepted, st_valid is high for one cycle. In that cycle, st_hdr_err, st_cnt_err and st_pay_err are each high exactly when the matching field differs from the computed value, and st_ovr_err is low.
- R5: Bit 61 of the first packet word sets the header length: two words when the bit is 1, one word when it is 0. If the packet is shorter than that, the header is the whole packet. The header CRC covers exactly the header words.
- R6: The payload CRC covers exactly the packet words after the header. It does not cover the end word.
- R7: The computed word count is the number of packet words plus one. Neither the start word nor the trailer is counted.
- R8: Both CRCs are seeded to zero at each start word. Each accepted word is folded in bit by bit from bit 63 down to bit 0. For each bit, fb = NOT(crc_msb XOR bit), then crc = (crc << 1) XOR (fb ? poly : 0). The header CRC uses 16 bits with poly 0x1021. The payload CRC uses 32 bits with poly 0x04C11DB7.
- R9: While out_valid is high and out_ready is low, out_data, out_last and out_valid hold. The input is stalled rather than dropped, so backpressure never loses or reorders a packet word.
- R10: If a packet word brings the count to MAX_WORDS without an end word, that word is forwarded with out_last high. st_valid then pulses with only st_ovr_err set, and the block returns to hunting.
- R11: While rst or clear is high, the block returns to hunting, drops any partial frame, empties its output register and clears its count and CRC state. After reset, out_valid and st_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous abandon of the current frame |
| in_data | input | 64 | Framed input word |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| out_data | output | 64 | Forwarded packet word |
| out_last | output | 1 | Final packet word of the frame |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream can take the output word |
| st_valid | output | 1 | One-cycle status strobe after each frame |
| st_hdr_err | output | 1 | Header CRC mismatch |
| st_cnt_err | output | 1 | Word count mismatch |
| st_pay_err | output | 1 | Payload CRC mismatch |
| st_ovr_err | output | 1 | Frame exceeded the word limit |

## Verification
Each trailer field is corrupted on its own in some frames and all together in another. A design that mixes up the trailer fields or the CRC coverage raises the wrong error bit or flags clean frames. Frames with the header flag set and clear, and a frame shorter than its header, catch a design that ignores bit 61 or lets the header CRC take in payload words. An empty frame, a stray end word while hunting, a word-limit overrun and a clear in the middle of a frame check that last is never placed on the wrong word or left off, and that a half-received frame never produces a strobe. Random backpressure checks that no word is lost, duplicated or changed while it is stalled.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
  localparam logic [63:0] START_WORD = 64'h9E6774129E677412;
  localparam logic [63:0] END_WORD   = 64'h2A1D632F2A1D632F;
  localparam logic [15:0] HDR_POLY   = 16'h1021;
  localparam logic [31:0] PAY_POLY   = 32'h04C11DB7;

  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_PKT   = 2'd1,
    ST_TRAIL = 2'd2,
    ST_FLUSH = 2'd3
  } dfr_state_e;
endpackage

// File: rtl/dfr_crc.sv
module dfr_crc #(
  parameter int W  = 16,
  parameter int DW = 64,
  parameter logic [W-1:0] POLY = W'(16'h1021)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          seed,
  input  logic          en,
  input  logic [DW-1:0] din,
  output logic [W-1:0]  crc
);
  function automatic logic [W-1:0] fold(input logic [W-1:0] c, input logic [DW-1:0] d);
    logic [W-1:0] r;
    r = c;
    for (int i = DW - 1; i >= 0; i--) begin
      if (~(r[W-1] ^ d[i])) r = {r[W-2:0], 1'b0} ^ POLY;
      else                  r = {r[W-2:0], 1'b0};
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || seed) crc <= '0;
    else if (en)     crc <= fold(crc, din);
  end

  AST_CRC_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!seed && !en) |=> $stable(crc)); // R8
  AST_CRC_SEEDED: assert property (@(posedge clk) disable iff (rst)
    seed |=> (crc == '0)); // R8
endmodule

// File: rtl/dfr_hold.sv
module dfr_hold #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          close,
  input  logic          out_ready,
  output logic          slot_free,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          out_valid
);
  logic [DW-1:0] held_d;
  logic          held_v;

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_v    <= 1'b0;
      held_d    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (push) begin
        if (held_v) begin
          out_valid <= 1'b1;
          out_data  <= held_d;
          out_last  <= 1'b0;
        end
        held_d <= push_data;
        held_v <= 1'b1;
      end else if (close) begin
        if (held_v) begin
          out_valid <= 1'b1;
          out_data  <= held_d;
          out_last  <= 1'b1;
        end
        held_v <= 1'b0;
      end
    end
  end

  AST_LOAD_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    (push || close) |-> slot_free); // R9
  AST_OUT_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R9
  AST_PUSH_CLOSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(push && close)); // R3
endmodule

// File: rtl/frame_deframer.sv
module frame_deframer import dfr_pkg::*; #(
  parameter int DATA_W    = 64,
  parameter int CNT_W     = 16,
  parameter int HCRC_W    = 16,
  parameter int PCRC_W    = 32,
  parameter int FLAG_BIT  = 61,
  parameter int MAX_WORDS = 65535
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              st_valid,
  output logic              st_hdr_err,
  output logic              st_cnt_err,
  output logic              st_pay_err,
  output logic              st_ovr_err
);
  localparam int PAY_LO  = 0;
  localparam int CNT_LO  = PCRC_W;
  localparam int HCRC_LO = PCRC_W + CNT_W;
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_WORDS);

  dfr_state_e state, state_nx;
  logic [CNT_W-1:0]  cnt, cnt_inc;
  logic              long_hdr;
  logic [HCRC_W-1:0] hdr_crc;
  logic [PCRC_W-1:0] pay_crc;
  logic              kill, acc, is_start, is_end;
  logic              pkt_acc, end_acc, start_acc, trail_acc, ovr_hit;
  logic              hdr_en, pay_en, slot_free, flush_go;

  assign kill      = rst || clear;
  assign is_start  = (in_data == START_WORD);
  assign is_end    = (in_data == END_WORD);
  assign acc       = in_valid && in_ready;
  assign cnt_inc   = cnt + CNT_W'(1);
  assign start_acc = (state == ST_HUNT)  && acc && is_start;
  assign pkt_acc   = (state == ST_PKT)   && acc && !is_end;
  assign end_acc   = (state == ST_PKT)   && acc && is_end;
  assign trail_acc = (state == ST_TRAIL) && acc;
  assign ovr_hit   = pkt_acc && (cnt_inc == MAX_CNT);
  assign flush_go  = (state == ST_FLUSH) && slot_free;
  assign hdr_en    = pkt_acc && ((cnt == '0) || ((cnt == CNT_W'(1)) && long_hdr));
  assign pay_en    = pkt_acc && !hdr_en;

  always_comb begin
    unique case (state)
      ST_HUNT:  in_ready = 1'b1;
      ST_PKT:   in_ready = slot_free;
      ST_TRAIL: in_ready = 1'b1;
      default:  in_ready = 1'b0;
    endcase
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_HUNT:  if (start_acc) state_nx = ST_PKT;
      ST_PKT: begin
        if (end_acc)      state_nx = ST_TRAIL;
        else if (ovr_hit) state_nx = ST_FLUSH;
      end
      ST_TRAIL: if (trail_acc) state_nx = ST_HUNT;
      default:  if (flush_go)  state_nx = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      state    <= ST_HUNT;
      cnt      <= '0;
      long_hdr <= 1'b0;
    end else begin
      state <= state_nx;
      if (start_acc) begin
        cnt      <= '0;
        long_hdr <= 1'b0;
      end else if (pkt_acc || end_acc) begin
        cnt <= cnt_inc;
      end
      if (pkt_acc && (cnt == '0)) long_hdr <= in_data[FLAG_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (kill) begin
      st_valid   <= 1'b0;
      st_hdr_err <= 1'b0;
      st_cnt_err <= 1'b0;
      st_pay_err <= 1'b0;
      st_ovr_err <= 1'b0;
    end else begin
      st_valid <= 1'b0;
      if (trail_acc) begin
        st_valid   <= 1'b1;
        st_hdr_err <= in_data[HCRC_LO +: HCRC_W] != hdr_crc;
        st_cnt_err <= in_data[CNT_LO +: CNT_W]   != cnt;
        st_pay_err <= in_data[PAY_LO +: PCRC_W]  != pay_crc;
        st_ovr_err <= 1'b0;
      end else if (flush_go) begin
        st_valid   <= 1'b1;
        st_hdr_err <= 1'b0;
        st_cnt_err <= 1'b0;
        st_pay_err <= 1'b0;
        st_ovr_err <= 1'b1;
      end
    end
  end

  dfr_crc #(.W(HCRC_W), .DW(DATA_W), .POLY(HCRC_W'(HDR_POLY))) u_hdr_crc (
    .clk(clk), .rst(kill), .seed(start_acc), .en(hdr_en), .din(in_data), .crc(hdr_crc)
  );

  dfr_crc #(.W(PCRC_W), .DW(DATA_W), .POLY(PCRC_W'(PAY_POLY))) u_pay_crc (
    .clk(clk), .rst(kill), .seed(start_acc), .en(pay_en), .din(in_data), .crc(pay_crc)
  );

  dfr_hold #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst(kill), .push(pkt_acc), .push_data(in_data),
    .close(end_acc || flush_go), .out_ready(out_ready), .slot_free(slot_free),
    .out_data(out_data), .out_last(out_last), .out_valid(out_valid)
  );

  AST_START_CLEARS_STATE: assert property (@(posedge clk) disable iff (kill)
    start_acc |=> (cnt == '0 && hdr_crc == '0 && pay_crc == '0)); // R8
  AST_STATUS_ONE_CYCLE: assert property (@(posedge clk) disable iff (kill)
    st_valid |=> !st_valid); // R4
  AST_OVR_ALONE: assert property (@(posedge clk) disable iff (kill)
    (st_valid && st_ovr_err) |-> !(st_hdr_err || st_cnt_err || st_pay_err)); // R10
  AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (kill)
    cnt <= MAX_CNT); // R10
  AST_HUNT_NO_STROBE: assert property (@(posedge clk) disable iff (kill)
    ($past(state) == ST_HUNT && state == ST_HUNT) |-> !st_valid); // R1
endmodule

// File: tb/sim_frame_deframer.sv
`timescale 1ns/1ps
module sim_frame_deframer;
  localparam int LIMIT = 12;
  localparam logic [63:0] SW = 64'h9E6774129E677412;
  localparam logic [63:0] EW = 64'h2A1D632F2A1D632F;
  // [15:8] packet words, [7] header flag, [6:4] corrupt {hdr,cnt,pay}, [3:0] expected {ovr,hdr,cnt,pay}
  localparam logic [15:0] VEC [7] = '{16'h0300, 16'h0580, 16'h04C4, 16'h0211,
                                      16'h0622, 16'h0180, 16'h07F7};

  logic clk = 1'b0;
  logic rst = 1'b1, clear = 1'b0;
  logic [63:0] in_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [63:0] out_data;
  logic out_last, out_valid;
  logic out_ready = 1'b1;
  logic st_valid, st_hdr_err, st_cnt_err, st_pay_err, st_ovr_err;

  int nchk = 0, nerr = 0, ncap = 0, nst = 0, stall_viol = 0;
  bit done = 1'b0, bp_mode = 1'b0;
  logic [63:0] cap_d [0:1023];
  logic        cap_l [0:1023];
  logic [3:0]  st_b  [0:255];
  logic        pv = 1'b0, pr = 1'b1, pl = 1'b0;
  logic [63:0] pd = '0;
  logic [15:0] lf = 16'hACE1;

  always #4 clk = ~clk;

  frame_deframer #(.MAX_WORDS(LIMIT)) u0 (
    .clk(clk), .rst(rst), .clear(clear), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_last(out_last), .out_valid(out_valid),
    .out_ready(out_ready), .st_valid(st_valid), .st_hdr_err(st_hdr_err),
    .st_cnt_err(st_cnt_err), .st_pay_err(st_pay_err), .st_ovr_err(st_ovr_err)
  );

  always @(posedge clk) begin
    #2;
    if (bp_mode) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_ready = lf[0] & lf[2];
    end else begin
      out_ready = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !clear) begin
      if (out_valid && out_ready && ncap < 1024) begin
        cap_d[ncap] = out_data; cap_l[ncap] = out_last; ncap++;
      end
      if (st_valid && nst < 256) begin
        st_b[nst] = {st_ovr_err, st_hdr_err, st_cnt_err, st_pay_err}; nst++;
      end
      if (pv && !pr && !(out_valid && out_data == pd && out_last == pl)) stall_viol++;
    end
    pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
  end

  function automatic logic [15:0] c16(input logic [15:0] c, input logic [63:0] d);
    for (int i = 63; i >= 0; i--) begin
      logic fb;
      fb = ~(c[15] ^ d[i]);
      c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return c;
  endfunction

  function automatic logic [31:0] c32(input logic [31:0] c, input logic [63:0] d);
    for (int i = 63; i >= 0; i--) begin
      logic fb;
      fb = ~(c[31] ^ d[i]);
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [63:0] pkt_word(input int f, input int k, input bit flag);
    logic [63:0] w;
    w = {16'hA5C3 ^ 16'(f), 16'(k), 32'(f * 1000 + k * 17 + 3)};
    if (k == 0) w[61] = flag;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [63:0] d);
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input int f, input int n, input bit flag, input logic [2:0] cor);
    logic [15:0] hc; logic [31:0] pc; logic [15:0] cn; int hl;
    hc = '0; pc = '0; cn = 16'(n + 1); hl = flag ? 2 : 1;
    push(SW);
    for (int k = 0; k < n; k++) begin
      if (k < hl) hc = c16(hc, pkt_word(f, k, flag));
      else        pc = c32(pc, pkt_word(f, k, flag));
      push(pkt_word(f, k, flag));
    end
    push(EW);
    push({hc ^ {15'd0, cor[2]}, cn ^ {15'd0, cor[1]}, pc ^ {31'd0, cor[0]}});
  endtask

  task automatic check_data(input int base, input int f, input int n, input bit flag, input string tag);
    bit okd, okl;
    okd = (ncap - base == n); okl = okd;
    for (int k = 0; k < n && okd; k++) begin
      if (cap_d[base + k] != pkt_word(f, k, flag)) okd = 1'b0;
      if (cap_l[base + k] != (k == n - 1)) okl = 1'b0;
    end
    chk(okd, {tag, " R2 data"}, 64'(ncap - base), 64'(n));
    chk(okl, {tag, " R3 last"}, 64'(ncap - base), 64'(n));
  endtask

  task automatic check_st(input int base, input logic [3:0] exp, input string tag);
    chk((nst - base == 1) && st_b[base] == exp, {tag, " R4 status"},
        (nst - base == 1) ? 64'(st_b[base]) : 64'hFFFF_0000 | 64'(nst - base), 64'(exp));
  endtask

  initial begin
    int cb, sb;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!out_valid && !st_valid && in_ready, "R11 reset", {61'd0, out_valid, st_valid, in_ready}, 64'd1);
    rst = 1'b0;
    @(negedge clk);

    // Table of frames: R5 R6 R7 R8 exercised through status
    foreach (VEC[i]) begin
      cb = ncap; sb = nst;
      send_frame(i + 1, int'(VEC[i][15:8]), VEC[i][7], VEC[i][6:4]);
      repeat (6) @(negedge clk);
      check_data(cb, i + 1, int'(VEC[i][15:8]), VEC[i][7], $sformatf("row%0d R5 R6 R7 R8", i));
      check_st(sb, VEC[i][3:0], $sformatf("row%0d", i));
    end

    // R1: junk and a stray end word while hunting
    cb = ncap; sb = nst;
    push(64'h0); push(64'h1234_5678_9ABC_DEF0); push(EW); push(64'hFFFF_FFFF_FFFF_FFFF);
    repeat (4) @(negedge clk);
    chk(ncap == cb && nst == sb, "R1 hunt drop", 64'(ncap - cb + nst - sb), 64'd0);
    send_frame(70, 3, 1'b0, 3'b000);
    repeat (6) @(negedge clk);
    check_data(cb, 70, 3, 1'b0, "R1 after hunt");
    check_st(sb, 4'b0000, "R1");

    // R3 R7: empty frame
    cb = ncap; sb = nst;
    push(SW); push(EW); push({16'h0, 16'h1, 32'h0});
    repeat (6) @(negedge clk);
    chk(ncap == cb, "R3 empty forwards nothing", 64'(ncap - cb), 64'd0);
    check_st(sb, 4'b0000, "R7 empty");

    // R9: random backpressure
    bp_mode = 1'b1;
    cb = ncap; sb = nst;
    send_frame(80, 6, 1'b1, 3'b000);
    repeat (80) @(negedge clk);
    bp_mode = 1'b0;
    repeat (4) @(negedge clk);
    check_data(cb, 80, 6, 1'b1, "R9 backpressure");
    check_st(sb, 4'b0000, "R9");
    chk(stall_viol == 0, "R9 stall hold", 64'(stall_viol), 64'd0);

    // R10: overrun at the word limit
    cb = ncap; sb = nst;
    push(SW);
    for (int k = 0; k < LIMIT; k++) push(pkt_word(50, k, 1'b0));
    repeat (6) @(negedge clk);
    check_data(cb, 50, LIMIT, 1'b0, "R10 overrun");
    check_st(sb, 4'b1000, "R10");
    cb = ncap; sb = nst;
    send_frame(51, 3, 1'b1, 3'b000);
    repeat (6) @(negedge clk);
    check_data(cb, 51, 3, 1'b1, "R10 recover");
    check_st(sb, 4'b0000, "R10 recover");

    // R11: clear in the middle of a frame
    push(SW); push(pkt_word(60, 0, 1'b0)); push(pkt_word(60, 1, 1'b0)); push(pkt_word(60, 2, 1'b0));
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    chk(!out_valid && in_ready, "R11 clear", {62'd0, out_valid, in_ready}, 64'd1);
    cb = ncap; sb = nst;
    send_frame(61, 4, 1'b0, 3'b000);
    repeat (6) @(negedge clk);
    check_data(cb, 61, 4, 1'b0, "R11 after clear");
    check_st(sb, 4'b0000, "R11 after clear");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule